// File: doc/BRIEF.md
# Two-Read One-Write Register Bank

This block is the general-purpose register storage of a single-cycle processor core. It holds a parameterized set of data words, 32 words of 32 bits by default. Two read ports return stored words with no clock delay. One write port stores a word, and only when its enable is high.

Writes commit on the falling edge of the clock. Within a single cycle, the core can write a result in the first half and read it back in the second half. Slot 0 is not storage. It always reads as zero, so software can use it as a constant and as a target for discarded results.

A synchronous reset clears every slot. The reset is sampled on the same falling edge as the writes, and it takes priority over a write at that edge.

The design has no state machine. Control is a one-hot write select, one storage slot per register and two independent read selectors.

Top module: `dual_read_regfile`

## Requirements
- R1: The bank holds DEPTH words of WIDTH bits, with defaults of 32 and 32. Ports index it with IDXW = clog2(DEPTH) bit indices.
- R2: Index 0 reads as all zeros on both read ports, even after a write to index 0 with the enable high.
- R3: Each read port returns the word stored at its index combinationally. A change of index changes the output with no clock edge, and each port is independent of the other.
- R4: A write of wr_data to wr_idx takes effect at a falling clock edge where wr_en is high and rst is low. Before that edge, a read of wr_idx returns the old word. After that edge, in the same cycle, it returns the new word.
- R5: When wr_en is low at a falling edge, no stored word changes.
- R6: When rst is high at a falling edge, every word becomes zero, even if a write is requested at that edge.
- R7: When both read ports carry the same index, they return the same word.
- R8: An enabled write changes only the word at wr_idx. Every other index keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; storage updates on its falling edge |
| rst | input | 1 | Synchronous active-high clear, sampled at the falling edge |
| rd_a_idx | input | IDXW | Index for read port A |
| rd_a_data | output | WIDTH | Word at rd_a_idx |
| rd_b_idx | input | IDXW | Index for read port B |
| rd_b_data | output | WIDTH | Word at rd_b_idx |
| wr_en | input | 1 | Write enable |
| wr_idx | input | IDXW | Index of the word to write |
| wr_data | input | WIDTH | Word to write |

## Verification
The bench fills every slot with a value unique to its index. It then sweeps both read ports across all indices, including two ports pointed at the same index. This tells a misrouted or aliased read selector apart from a correct one.

Each single write is sampled twice, once before and once after the falling edge of its cycle. This separates a correct falling-edge commit from a rising-edge commit and from a purely combinational pass-through.

Writes with the enable low, writes to index 0, and a reset raised together with a pending write cover the three ways a word must stay fixed or be cleared. After every targeted write, a full sweep of the bank catches a write decoder that touches neighbouring slots.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
    // Default geometry of the register bank.
    localparam int unsigned RF_DEF_DEPTH = 32;
    localparam int unsigned RF_DEF_WIDTH = 32;
endpackage

// File: rtl/rf_wr_decode.sv
// Turns the write index and enable into a one-hot select over slots 1..DEPTH-1.
// Slot 0 has no select line, so it can never be written.
module rf_wr_decode #(
    parameter int unsigned DEPTH = 32,
    localparam int unsigned IDXW = $clog2(DEPTH)
) (
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    output logic [DEPTH-1:1] sel
);
    for (genvar g = 1; g < DEPTH; g++) begin : g_sel
        assign sel[g] = wr_en && (wr_idx == IDXW'(g));
    end
endmodule

// File: rtl/rf_entry.sv
// One storage word. It updates on the falling clock edge.
module rf_entry #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    always_ff @(negedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (we) begin
            q <= d;
        end
    end

    // R6: reset at a falling edge leaves the word cleared.
    p_reset_clears_r6: assert property (@(negedge clk) rst |=> (q == '0))
        else $error("R6 word not cleared by reset");

    // R4: an enabled write is held by the word until the next falling edge.
    p_write_lands_r4: assert property (@(negedge clk) disable iff (rst)
        we |=> (q == $past(d)))
        else $error("R4 written word not stored");

    // R5: with no select on this word, it keeps its value across the edge.
    p_hold_when_idle_r5: assert property (@(negedge clk) disable iff (rst)
        !we |=> $stable(q))
        else $error("R5 word changed without a write");
endmodule

// File: rtl/rf_read_port.sv
// Combinational read selector. Index 0, and any index past the bank, returns zero.
module rf_read_port #(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned WIDTH = 32,
    localparam int unsigned IDXW = $clog2(DEPTH)
) (
    input  logic [IDXW-1:0]  idx,
    input  logic [WIDTH-1:0] bank [1:DEPTH-1],
    output logic [WIDTH-1:0] data
);
    always_comb begin
        data = '0;
        for (int i = 1; i < DEPTH; i++) begin
            if (idx == IDXW'(i)) begin
                data = bank[i];
            end
        end
    end
endmodule

// File: rtl/dual_read_regfile.sv
module dual_read_regfile #(
    parameter int unsigned DEPTH = regfile_pkg::RF_DEF_DEPTH,
    parameter int unsigned WIDTH = regfile_pkg::RF_DEF_WIDTH,
    localparam int unsigned IDXW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDXW-1:0]  rd_a_idx,
    output logic [WIDTH-1:0] rd_a_data,
    input  logic [IDXW-1:0]  rd_b_idx,
    output logic [WIDTH-1:0] rd_b_data,
    input  logic             wr_en,
    input  logic [IDXW-1:0]  wr_idx,
    input  logic [WIDTH-1:0] wr_data
);
    logic [DEPTH-1:1] wr_sel;
    logic [WIDTH-1:0] bank [1:DEPTH-1];

    rf_wr_decode #(.DEPTH(DEPTH)) u_dec (
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .sel    (wr_sel)
    );

    for (genvar g = 1; g < DEPTH; g++) begin : g_word
        rf_entry #(.WIDTH(WIDTH)) u_word (
            .clk (clk),
            .rst (rst),
            .we  (wr_sel[g]),
            .d   (wr_data),
            .q   (bank[g])
        );
    end

    rf_read_port #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rd_a (
        .idx  (rd_a_idx),
        .bank (bank),
        .data (rd_a_data)
    );

    rf_read_port #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rd_b (
        .idx  (rd_b_idx),
        .bank (bank),
        .data (rd_b_data)
    );

    // R8: at most one word is selected for writing.
    p_single_target_r8: assert property (@(negedge clk) disable iff (rst)
        $onehot0(wr_sel))
        else $error("R8 more than one word selected");

    // R5: no select line is active while the enable is low.
    p_no_sel_idle_r5: assert property (@(negedge clk) disable iff (rst)
        !wr_en |-> (wr_sel == '0))
        else $error("R5 select active with enable low");

    // R2: index 0 reads zero on both ports.
    p_zero_a_r2: assert property (@(posedge clk) disable iff (rst)
        (rd_a_idx == '0) |-> (rd_a_data == '0))
        else $error("R2 port A index 0 not zero");
    p_zero_b_r2: assert property (@(posedge clk) disable iff (rst)
        (rd_b_idx == '0) |-> (rd_b_data == '0))
        else $error("R2 port B index 0 not zero");

    // R7: matching indices give matching words.
    p_ports_agree_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_a_idx == rd_b_idx) |-> (rd_a_data == rd_b_data))
        else $error("R7 ports disagree on same index");
endmodule

// File: tb/dual_read_regfile_tb_top.sv
module dual_read_regfile_tb_top;
    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned DEPTH = 32;
    localparam int unsigned WIDTH = 32;
    localparam int unsigned IDXW = $clog2(DEPTH);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [IDXW-1:0]  rd_a_idx = '0;
    logic [IDXW-1:0]  rd_b_idx = '0;
    logic [WIDTH-1:0] rd_a_data;
    logic [WIDTH-1:0] rd_b_data;
    logic             wr_en = 1'b0;
    logic [IDXW-1:0]  wr_idx = '0;
    logic [WIDTH-1:0] wr_data = '0;

    logic [WIDTH-1:0] model [DEPTH];
    int total = 0;
    int bad = 0;

    dual_read_regfile #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .rd_a_idx  (rd_a_idx),
        .rd_a_data (rd_a_data),
        .rd_b_idx  (rd_b_idx),
        .rd_b_data (rd_b_data),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [WIDTH-1:0] act,
                         input logic [WIDTH-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [WIDTH-1:0] pattern(input int i, input int seed);
        return WIDTH'(32'h9E37_79B9 * (i + 1) ^ (seed << 8) ^ i);
    endfunction

    // Reads every index on both ports and compares against the model.
    task automatic sweep(input string req);
        for (int i = 0; i < DEPTH; i++) begin
            rd_a_idx = IDXW'(i);
            rd_b_idx = IDXW'(DEPTH - 1 - i);
            #1;
            check(req, rd_a_data, model[i]);
            check(req, rd_b_data, model[DEPTH - 1 - i]);
        end
    endtask

    // One write cycle. Inputs change just after the rising edge, the
    // old word is checked before the falling edge, the new word after it.
    task automatic do_write(input logic en, input int idx,
                            input logic [WIDTH-1:0] val, input string req);
        logic [WIDTH-1:0] old;
        @(posedge clk);
        #1;
        wr_en = en;
        wr_idx = IDXW'(idx);
        wr_data = val;
        rd_a_idx = IDXW'(idx);
        old = model[idx];
        #1;
        check(req, rd_a_data, old);
        @(negedge clk);
        #1;
        if (en && idx != 0) model[idx] = val;
        check(req, rd_a_data, model[idx]);
        wr_en = 1'b0;
    endtask

    task automatic t_reset_state();
        sweep("R6 reset state");
    endtask

    task automatic t_fill_all();
        for (int i = 0; i < DEPTH; i++) begin
            do_write(1'b1, i, pattern(i, 1), "R4 fill write");
        end
        sweep("R1 R3 R8 full sweep after fill");
    endtask

    task automatic t_zero_slot();
        do_write(1'b1, 0, '1, "R2 write to index 0");
        rd_a_idx = '0;
        rd_b_idx = '0;
        #1;
        check("R2 port A index 0", rd_a_data, '0);
        check("R2 port B index 0", rd_b_data, '0);
    endtask

    task automatic t_disabled_write();
        do_write(1'b0, 7, 32'hDEAD_BEEF, "R5 disabled write");
        do_write(1'b0, DEPTH - 1, 32'h1234_5678, "R5 disabled write top");
        sweep("R5 sweep after disabled writes");
    endtask

    task automatic t_single_writes();
        do_write(1'b1, 1, 32'h0000_0001, "R4 low index");
        do_write(1'b1, DEPTH - 1, 32'hFFFF_FFFF, "R4 top index");
        do_write(1'b1, 16, 32'hA5A5_5A5A, "R4 middle index");
        do_write(1'b1, 16, 32'h5A5A_A5A5, "R4 overwrite");
        sweep("R8 sweep after single writes");
    endtask

    task automatic t_same_index();
        for (int i = 0; i < DEPTH; i += 5) begin
            rd_a_idx = IDXW'(i);
            rd_b_idx = IDXW'(i);
            #1;
            check("R7 port A same index", rd_a_data, model[i]);
            check("R7 ports agree", rd_b_data, rd_a_data);
        end
    endtask

    task automatic t_comb_read();
        // The index changes between edges; the output must follow at once.
        @(posedge clk);
        #1;
        rd_a_idx = IDXW'(3);
        #1;
        check("R3 comb read first", rd_a_data, model[3]);
        rd_a_idx = IDXW'(9);
        #1;
        check("R3 comb read second", rd_a_data, model[9]);
    endtask

    task automatic t_reset_beats_write();
        @(posedge clk);
        #1;
        rst = 1'b1;
        wr_en = 1'b1;
        wr_idx = IDXW'(12);
        wr_data = 32'hCAFE_F00D;
        @(negedge clk);
        #1;
        rst = 1'b0;
        wr_en = 1'b0;
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        sweep("R6 reset with pending write");
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        repeat (2) @(negedge clk);
        @(posedge clk);
        #1;
        rst = 1'b0;
        t_reset_state();
        t_fill_all();
        t_zero_slot();
        t_disabled_write();
        t_single_writes();
        t_same_index();
        t_comb_read();
        t_reset_beats_write();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule